// File: doc/BRIEF.md
# Stored Random Sequence Byte Playback

This block holds a pseudorandom bit pattern, packed eight bits to a byte, in an on-chip RAM. It plays the pattern back one byte per reference-clock period to a downstream parallel-to-serial converter. The reference clock is the serializer's divide-by-eight output clock, so each byte presented becomes eight line bits. A host loads the bytes through a dedicated write port while playback is stopped. It also programs a last-address value, which sets the period of the repeating sequence. A different pattern or length therefore needs no change to the logic.

During playback an address counter steps through the RAM on rising edges of the reference clock. The RAM is read on the falling edge, which is the rising edge of the inverted reference clock, so each address has had half a period to settle before it is used. The read enable is the count enable delayed by one flip-flop. Because of that delay, the first read edge after enabling always falls on a settled address 0. A registered byte and a byte-valid strobe leave the block on the following rising edge. Host writes attempted during playback are dropped and reported by an error pulse.

Top module: `seqbyte_player`

## Requirements
- R1: While playback is idle (count enable low and the internal read enable low), a write with `wr_en` high stores `wr_data` at `wr_addr`; any address in the RAM can be written.
- R2: While playback runs, the bytes leave in ascending address order, one byte on every rising edge of `clk`, the read address rising by exactly one per edge.
- R3: The RAM is read on the falling edge of `clk` (the inverted reference clock), using the address the counter produced on the preceding rising edge.
- R4: The read enable is `count_en` registered once on the rising edge. If `count_en` is sampled high at rising edge k, the byte at address 0 appears on `byte_out` with `byte_valid` high just after rising edge k+1.
- R5: A last-address value, written through `cfg_we`/`cfg_last` while idle, sets the sequence length to last+1 bytes. After the byte at the last address comes the byte at address 0, so the sequence repeats with that period. The value is any address from 0 to DEPTH-1.
- R6: A byte write or a last-address write requested while playback is busy (count enable or read enable high) changes nothing. `wr_err` is high just after the next rising edge for each such rejected request, and low otherwise.
- R7: When `count_en` is sampled low at rising edge j, one final valid byte (the next byte in the sequence) is presented after edge j. `byte_valid` is low after edge j+1, and the address returns to 0, so the next playback starts again from address 0.
- R8: After the synchronous active-high reset, `byte_out` is 0, `byte_valid` and `wr_err` are 0, and the last address is DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (serializer divide-by-eight clock) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write request |
| wr_addr | input | ADDR_W | Host byte write address |
| wr_data | input | DATA_W | Host byte write data |
| cfg_we | input | 1 | Host request to load the last-address value |
| cfg_last | input | ADDR_W | Last address of the sequence |
| count_en | input | 1 | Playback enable |
| byte_out | output | DATA_W | Byte presented to the serializer |
| byte_valid | output | 1 | High while `byte_out` carries a sequence byte |
| wr_err | output | 1 | Pulse marking a host request rejected during playback |

## Verification
The bench drives every input just after a rising edge and samples all outputs just after a rising edge. Each expected value is therefore placed at an exact edge count. The first byte is due on the second rising edge after `count_en` is set, since the enable flop samples it at the first edge, the falling-edge RAM read follows, and the output register loads at the second edge. Every later byte is due one edge after the previous one. A rejected write shows up on `wr_err` one edge after the request. After `count_en` is cleared, the last valid byte is due one edge later and `byte_valid` goes low one edge after that. Sweeps over every sequence length from one to eight bytes, and over the full RAM depth, compare each byte with the loaded table indexed by position modulo length.

// File: rtl/seqbyte_pkg.sv
package seqbyte_pkg;
  // playback phase seen by the host-side guard
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ARMED = 2'b01,
    PH_RUN   = 2'b11,
    PH_DRAIN = 2'b10
  } play_phase_e;

  function automatic play_phase_e phase_of(input logic en, input logic rd);
    case ({rd, en})
      2'b00:   return PH_IDLE;
      2'b01:   return PH_ARMED;
      2'b11:   return PH_RUN;
      default: return PH_DRAIN;
    endcase
  endfunction
endpackage

// File: rtl/seqbyte_ram.sv
module seqbyte_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write port on the reference clock
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read port on the inverted reference clock: address settled half a period
  always_ff @(negedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seqbyte_addr_gen.sv
module seqbyte_addr_gen #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam logic [ADDR_W-1:0] LAST_RST = ADDR_W'(DEPTH - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_last,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en
);
  logic [ADDR_W-1:0] last_q;
  logic              at_last;

  assign at_last = (rd_addr == last_q);

  always_ff @(posedge clk) begin
    if (rst)           last_q <= LAST_RST;
    else if (cfg_load) last_q <= cfg_last;
  end

  // enable resynchronizer: reads start only after a full setup period
  always_ff @(posedge clk) begin
    if (rst) rd_en <= 1'b0;
    else     rd_en <= count_en;
  end

  // counter advances only once reading is under way, so address 0 is read first
  always_ff @(posedge clk) begin
    if (rst || !count_en)  rd_addr <= '0;
    else if (rd_en) begin
      if (at_last) rd_addr <= '0;
      else         rd_addr <= rd_addr + 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (count_en && rd_en && !at_last) |=> (rd_addr == $past(rd_addr) + 1'b1)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (count_en && rd_en && at_last) |=> (rd_addr == '0)); // R5
  AST_FIRST_READ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (rd_addr == '0)); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> (rd_addr == '0 && !rd_en)); // R7
endmodule

// File: rtl/seqbyte_wr_guard.sv
module seqbyte_wr_guard
  import seqbyte_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic cfg_we,
  input  logic count_en,
  input  logic rd_en,
  output logic ram_we,
  output logic cfg_load,
  output logic err_q
);
  play_phase_e phase;
  logic        idle;

  assign phase    = phase_of(count_en, rd_en);
  assign idle     = (phase == PH_IDLE);
  assign ram_we   = wr_en  && idle;
  assign cfg_load = cfg_we && idle;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (wr_en || cfg_we) && !idle;
  end

  AST_NO_WRITE_IN_PLAY: assert property (@(posedge clk) disable iff (rst)
    (ram_we || cfg_load) |-> (!count_en && !rd_en)); // R6
  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || cfg_we) && count_en) |=> err_q); // R6
endmodule

// File: rtl/seqbyte_player.sv
module seqbyte_player #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_last,
  input  logic              count_en,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              wr_err
);
  logic              ram_we;
  logic              cfg_load;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  seqbyte_wr_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .cfg_we   (cfg_we),
    .count_en (count_en),
    .rd_en    (rd_en),
    .ram_we   (ram_we),
    .cfg_load (cfg_load),
    .err_q    (wr_err)
  );

  seqbyte_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .cfg_load (cfg_load),
    .cfg_last (cfg_last),
    .rd_addr  (rd_addr),
    .rd_en    (rd_en)
  );

  seqbyte_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // registered outputs toward the serializer
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= rd_en;
      if (rd_en) byte_out <= rd_data;
    end
  end

  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(rd_en)); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !$past(byte_valid)) |-> $stable(byte_out)); // R7
endmodule

// File: tb/seqbyte_player_bench.sv
module seqbyte_player_bench;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_last = '0;
  logic              count_en = 1'b0;
  logic [DATA_W-1:0] byte_out;
  logic              byte_valid;
  logic              wr_err;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] table_q [DEPTH];

  always #10 clk = ~clk;

  seqbyte_player #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seqbyte_player (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_last(cfg_last), .count_en(count_en),
    .byte_out(byte_out), .byte_valid(byte_valid), .wr_err(wr_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive after an edge, one edge consumes it
  task automatic put_byte(input int a, input int d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
    table_q[a] = DATA_W'(d);
  endtask

  task automatic set_last(input int l);
    cfg_we = 1'b1; cfg_last = ADDR_W'(l);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // play n bytes of a sequence of length len, then stop and check the drain
  task automatic play(input int len, input int n, input string req);
    count_en = 1'b1;
    @(posedge clk); #1;                    // enable flop samples
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check(req, int'(byte_valid), 1);
      check(req, int'(byte_out), int'(table_q[i % len]));
    end
    count_en = 1'b0;
    @(posedge clk); #1;                    // R7: one final byte
    check("R7", int'(byte_valid), 1);
    check("R7", int'(byte_out), int'(table_q[n % len]));
    @(posedge clk); #1;
    check("R7", int'(byte_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R8", int'(byte_out), 0);
    check("R8", int'(byte_valid), 0);
    check("R8", int'(wr_err), 0);

    // R1: load the sequence bytes, then the remaining addresses
    put_byte(0, 'hA8); put_byte(1, 'hD7); put_byte(2, 'h2A); put_byte(3, 'h82);
    put_byte(4, 'hCA); put_byte(5, 'h62); put_byte(6, 'h54); put_byte(7, 'hD1);
    for (int a = 8; a < DEPTH; a++) put_byte(a, (a * 37 + 5) & 255);

    // R8: reset last address is DEPTH-1, so full depth plays and wraps
    play(DEPTH, DEPTH + 2, "R8");

    // R2 R3 R4 R5: eight-byte stream wrapping back to A8
    set_last(7);
    play(8, 17, "R5");

    // R5: every length from 1 to 8
    for (int l = 1; l <= 8; l++) begin
      set_last(l - 1);
      play(l, 2 * l + 1, "R2");
    end

    // R6: writes during playback are dropped and flagged
    set_last(7);
    count_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = '0; wr_data = 8'hFF;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R6", int'(wr_err), 1);
    cfg_we = 1'b1; cfg_last = 4'd1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check("R6", int'(wr_err), 1);
    @(posedge clk); #1;
    check("R6", int'(wr_err), 0);
    count_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // contents and length unchanged: full 8-byte stream with wrap
    play(8, 9, "R6");

    // R1: idle write accepted, no error, visible in playback
    put_byte(3, 'h5C);
    check("R1", int'(wr_err), 0);
    play(8, 8, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule